// File: doc/BRIEF.md
# UART Receive Double Buffer

This block sits between a UART receive shift register and a byte-wide register read port. It holds up to two received frames of up to nine data bits each. Each frame carries its own frame-error and parity-error flags. The oldest stored frame is presented as two registered bytes: a low byte with data bits 7..0, and a high byte that combines a receive-complete flag, a sticky overflow flag, the stored frame's error flags and data bit 8.

Software reads the pair of bytes. Exactly one of the two reads advances the buffer. When nine-bit frames are read low byte first, the high-byte read advances it. In every other mode, the low-byte read advances it. The other byte can therefore always be read first without losing anything.

A third frame that completes while both entries are full waits in the shift-register stage and moves into the buffer on the next advancing read. If a new start bit arrives before that happens, the waiting frame is lost and the overflow flag is raised.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After a synchronous reset, both `rd_data_lo` and `rd_data_hi` read 0x00.
- R2: The buffer holds two frames in arrival order. `rd_data_lo` shows data bits 7..0 of the oldest frame, and `rd_data_hi` bit 0 shows its data bit 8.
- R3: With `cfg_nine_lo_first`=1, a pulse on `rd_hi` advances the buffer. With `cfg_nine_lo_first`=0, a pulse on `rd_lo` advances it.
- R4: A read of the byte that does not advance the buffer leaves both output bytes unchanged.
- R5: `rd_data_hi` bit 7 is 1 exactly when at least one frame is stored.
- R6: A frame that completes while both entries are full waits, and it enters the buffer on the next advancing read. If `start_det` pulses while a frame waits and no advancing read happens in that cycle, the waiting frame is discarded and `rd_data_hi` bit 6 (overflow) becomes 1. A second completed frame that arrives while one already waits replaces it and also sets overflow.
- R7: Any advancing read clears overflow.
- R8: `rd_data_hi` bit 2 is the stored frame's frame-error flag and bit 1 is its parity-error flag. Bits 5..3 always read 0.
- R9: When an advancing read and a frame completion fall in the same cycle on a full buffer, the oldest frame is removed, the new frame is stored, and overflow stays 0.
- R10: When the buffer is empty, `rd_data_lo` is 0x00 and bits 7, 2, 1 and 0 of `rd_data_hi` are 0. An advancing read on an empty buffer changes nothing except clearing overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nine_lo_first | input | 1 | 1: nine-bit frames read low byte first, so the high-byte read advances |
| frm_valid | input | 1 | One-cycle strobe: a received frame is complete |
| frm_data | input | 9 | Received data bits |
| frm_ferr | input | 1 | First stop bit sampled as 0 |
| frm_perr | input | 1 | Parity checking enabled and parity wrong |
| start_det | input | 1 | One-cycle pulse: a new start bit was detected |
| rd_lo | input | 1 | Read strobe for the low byte |
| rd_hi | input | 1 | Read strobe for the high byte |
| rd_data_lo | output | 8 | Registered low byte of the oldest frame |
| rd_data_hi | output | 8 | Registered status byte: {rxc, ovf, 0, 0, 0, ferr, perr, d8} |

## Verification
All results are due on the rising edge that samples the stimulus. The output registers load from the next-state values of the storage and flags, so a push, pop, overflow set or clear is visible right after that single edge. The bench drives strobes at the falling edge, advances its reference model at the next rising edge, and compares both bytes at the following falling edge. No result is expected later than one edge after its cause.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int RX_DW = 9;

  typedef struct packed {
    logic             ferr;
    logic             perr;
    logic [RX_DW-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  rx_entry_t                    wr_ent,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output rx_entry_t                    head_nx,
  output logic                         nonempty_nx
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  rx_entry_t         mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr, rd_nx;
  logic [CW-1:0]     count_nx, after_pop;
  logic              bypass;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_comb begin
    rd_nx       = pop ? bump(rd_ptr) : rd_ptr;
    after_pop   = count - (pop ? CW'(1) : CW'(0));
    count_nx    = after_pop + (push ? CW'(1) : CW'(0));
    bypass      = push && (after_pop == '0);
    head_nx     = bypass ? wr_ent : mem[rd_nx];
    nonempty_nx = (count_nx != '0);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      rd_ptr <= rd_nx;
      count  <= count_nx;
    end
  end

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R9: simultaneous push and pop keeps occupancy
  a_r9_push_pop_level: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(count));

  // R10: a pop on empty must never be requested
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/rxbuf_hold.sv
module rxbuf_hold
  import rxbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frm_valid,
  input  rx_entry_t frm_ent,
  input  logic      start_det,
  input  logic      pop,
  input  logic      adv,
  input  logic      full,
  output logic      push,
  output rx_entry_t push_ent,
  output logic      ovf_nx,
  output logic      ovf_q
);
  rx_entry_t pend;
  logic      pend_v, pend_v_nx, capture, ovf_set;

  always_comb begin
    push     = pend_v ? pop : (frm_valid && (!full || pop));
    push_ent = pend_v ? pend : frm_ent;
    ovf_set  = pend_v && !pop && (frm_valid || start_det);
    capture  = frm_valid && (pend_v || (full && !pop));
    if (pend_v) begin
      if (pop)            pend_v_nx = frm_valid;
      else if (frm_valid) pend_v_nx = 1'b1;
      else                pend_v_nx = !start_det;
    end else begin
      pend_v_nx = frm_valid && full && !pop;
    end
    ovf_nx = ovf_set || (ovf_q && !adv);
  end

  always_ff @(posedge clk) begin
    if (capture) pend <= frm_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_v <= pend_v_nx;
      ovf_q  <= ovf_nx;
    end
  end

  // R6: a waiting frame only exists while both entries are occupied
  a_r6_wait_needs_full: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> full);

  // R6: start bit with a waiting frame and no advancing read raises overflow
  a_r6_ovf_on_start: assert property (@(posedge clk) disable iff (rst)
    (pend_v && start_det && !pop) |=> ovf_q);

  // R7: an advancing read without a new overflow condition clears the flag
  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (adv && !pend_v) |=> !ovf_q);
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
  import rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rx_entry_t  head_nx,
  input  logic       nonempty_nx,
  input  logic       ovf_nx,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q
);
  logic [7:0] lo_nx, hi_nx;

  always_comb begin
    lo_nx = '0;
    hi_nx = '0;
    hi_nx[6] = ovf_nx;
    if (nonempty_nx) begin
      lo_nx    = head_nx.data[7:0];
      hi_nx[7] = 1'b1;
      hi_nx[2] = head_nx.ferr;
      hi_nx[1] = head_nx.perr;
      hi_nx[0] = head_nx.data[RX_DW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_nx;
    end
  end
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_nine_lo_first,
  input  logic             frm_valid,
  input  logic [RX_DW-1:0] frm_data,
  input  logic             frm_ferr,
  input  logic             frm_perr,
  input  logic             start_det,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [7:0]       rd_data_lo,
  output logic [7:0]       rd_data_hi
);
  localparam int CW = $clog2(DEPTH+1);

  rx_entry_t     frm_ent, push_ent, head_nx;
  logic          adv, other_rd, pop, push, full, empty, nonempty_nx;
  logic          ovf_nx, ovf_q;
  logic [CW-1:0] count;

  assign frm_ent  = '{ferr: frm_ferr, perr: frm_perr, data: frm_data};
  assign adv      = cfg_nine_lo_first ? rd_hi : rd_lo;
  assign other_rd = cfg_nine_lo_first ? rd_lo : rd_hi;
  assign pop      = adv && !empty;

  rxbuf_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_ent   (frm_ent),
    .start_det (start_det),
    .pop       (pop),
    .adv       (adv),
    .full      (full),
    .push      (push),
    .push_ent  (push_ent),
    .ovf_nx    (ovf_nx),
    .ovf_q     (ovf_q)
  );

  rxbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .pop         (pop),
    .wr_ent      (push_ent),
    .count       (count),
    .full        (full),
    .empty       (empty),
    .head_nx     (head_nx),
    .nonempty_nx (nonempty_nx)
  );

  rxbuf_status u_status (
    .clk         (clk),
    .rst         (rst),
    .head_nx     (head_nx),
    .nonempty_nx (nonempty_nx),
    .ovf_nx      (ovf_nx),
    .lo_q        (rd_data_lo),
    .hi_q        (rd_data_hi)
  );

  // R5: receive-complete bit follows storage occupancy
  a_r5_rxc_tracks: assert property (@(posedge clk) disable iff (rst)
    rd_data_hi[7] == (count != '0));

  // R6: overflow bit on the port mirrors the flag register
  a_r6_ovf_port: assert property (@(posedge clk) disable iff (rst)
    rd_data_hi[6] == ovf_q);

  // R4: a lone non-advancing read leaves both bytes untouched
  a_r4_side_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (other_rd && !adv && !frm_valid && !start_det) |=>
      ($stable(rd_data_lo) && $stable(rd_data_hi)));
endmodule

// File: tb/uart_rx_dbuf_bench.sv
`timescale 1ns/100ps
module uart_rx_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg = 1'b0;
  logic       fv = 1'b0, fe = 1'b0, pe = 1'b0, st = 1'b0, rl = 1'b0, rh = 1'b0;
  logic [8:0] fd = '0;
  logic [7:0] lo, hi;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [10:0] m_q[$];
  logic [10:0] m_pend;
  bit          m_pv, m_ovf;

  always #2.5 clk = ~clk;

  uart_rx_dbuf u_uart_rx_dbuf (
    .clk(clk), .rst(rst), .cfg_nine_lo_first(cfg),
    .frm_valid(fv), .frm_data(fd), .frm_ferr(fe), .frm_perr(pe),
    .start_det(st), .rd_lo(rl), .rd_hi(rh),
    .rd_data_lo(lo), .rd_data_hi(hi));

  function automatic logic [7:0] exp_lo();
    return (m_q.size() > 0) ? m_q[0][7:0] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_hi();
    logic [7:0] h = '0;
    h[6] = m_ovf;
    if (m_q.size() > 0) begin
      h[7] = 1'b1;
      h[2] = m_q[0][10];
      h[1] = m_q[0][9];
      h[0] = m_q[0][8];
    end
    return h;
  endfunction

  task automatic model_step();
    bit adv = cfg ? rh : rl;
    bit pop = adv && (m_q.size() > 0);
    logic [10:0] nf = {fe, pe, fd};
    if (adv) m_ovf = 1'b0;
    if (pop) void'(m_q.pop_front());
    if (m_pv && pop) begin
      m_q.push_back(m_pend);
      m_pv = 1'b0;
    end
    if (fv) begin
      if (m_q.size() < 2) m_q.push_back(nf);
      else begin
        if (m_pv) m_ovf = 1'b1;
        m_pend = nf;
        m_pv   = 1'b1;
      end
    end else if (st && m_pv) begin
      m_pv  = 1'b0;
      m_ovf = 1'b1;
    end
  endtask

  task automatic chk(input string tag);
    logic [7:0] el = exp_lo();
    logic [7:0] eh = exp_hi();
    checks++;
    if (lo !== el || hi !== eh) begin
      failures++;
      $display("FAIL %s: lo=%02h hi=%02h expected lo=%02h hi=%02h", tag, lo, hi, el, eh);
    end
  endtask

  task automatic cyc(input bit v, input logic [8:0] d, input bit e, input bit p,
                     input bit s, input bit a, input bit b, input string tag);
    fv = v; fd = d; fe = e; pe = p; st = s; rl = a; rh = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    fv = 0; st = 0; rl = 0; rh = 0;
    chk(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pv = 0; m_ovf = 0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1");
    // mode 0: low byte advances
    cyc(1, 9'h1A5, 0, 0, 0, 0, 0, "R5");
    cyc(1, 9'h03C, 0, 0, 0, 0, 0, "R2");
    cyc(1, 9'h077, 0, 0, 0, 0, 0, "R6");
    cyc(0, 9'h000, 0, 0, 1, 0, 0, "R6");
    cyc(0, 9'h000, 0, 0, 0, 0, 1, "R4");
    cyc(0, 9'h000, 0, 0, 0, 1, 0, "R7");
    cyc(0, 9'h000, 0, 0, 0, 1, 0, "R10");
    cyc(0, 9'h000, 0, 0, 0, 1, 0, "R10");
    cyc(1, 9'h155, 1, 1, 0, 0, 0, "R8");
    cyc(1, 9'h0AA, 0, 1, 0, 0, 0, "R8");
    cyc(1, 9'h1F0, 1, 0, 0, 1, 0, "R9");
    cyc(1, 9'h00F, 0, 0, 0, 0, 0, "R6");
    cyc(0, 9'h000, 0, 0, 0, 1, 0, "R6");
    // mode 1: high byte advances
    cfg = 1'b1;
    cyc(0, 9'h000, 0, 0, 0, 1, 0, "R4");
    cyc(0, 9'h000, 0, 0, 0, 0, 1, "R3");
    cyc(1, 9'h111, 0, 0, 0, 0, 0, "R6");
    cyc(1, 9'h122, 0, 0, 0, 0, 0, "R6");
    cyc(0, 9'h000, 0, 0, 0, 0, 1, "R3");
    cyc(0, 9'h000, 0, 0, 0, 0, 1, "R3");
    cyc(0, 9'h000, 0, 0, 0, 0, 1, "R10");
    for (int m = 0; m < 2; m++) begin
      cfg = m[0];
      for (int i = 0; i < 3000; i++) begin
        bit v = ($urandom_range(0, 99) < 45);
        bit s = !v && ($urandom_range(0, 99) < 25);
        cyc(v, 9'($urandom), 1'($urandom), 1'($urandom), s,
            ($urandom_range(0, 99) < 30), ($urandom_range(0, 99) < 30), "R2");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule